// File: doc/BRIEF.md
# Nonvolatile Save/Restore Cycle Controller

This controller runs the bulk transfers between a volatile working array and its nonvolatile shadow. A save first erases the shadow and then programs every shadow cell from the working array in one parallel step. A restore first clears the working array and then copies the shadow into it. The shadow is never altered by a restore. While either transfer runs, the external access path is shut off.

Transfers start in four ways. Software can ask for a save or a restore through single-cycle request pulses from an external sequence detector. A falling supply-sense flag starts an automatic save, but only when a write has landed since the last completed transfer. The automatic save begins after a short grace window that lets an access already in flight finish. A rising supply-sense flag starts an automatic restore. A restore requested while supply is low is held and served at the next rise. A software save is abandoned if supply sense drops during it. Restores always run to completion. Every phase length comes from a clock-count parameter. Supply sense arrives already synchronised to the clock.

Top module: `nv_xfer_ctrl`

## Requirements
- R1: After reset, with supply sense low, busy_o, bus_block_o and all four phase strobes are low, and they stay low with no request present.
- R2: A rise of pwr_ok_i while idle is accepted in the same cycle. It is followed by CLR_CYC cycles of clr_o, then PU_RST_CYC cycles of copy_o, then one cycle with busy_o high and no strobe. A software save pulse in the same cycle as the rise is dropped.
- R3: A software restore (sw_restore_i with supply high, while idle) runs CLR_CYC cycles of clr_o and then SW_RST_CYC cycles of copy_o. A fall of supply sense during it neither shortens it nor starts a save.
- R4: A software save (sw_save_i with supply high, while idle) runs ERASE_CYC cycles of erase_o and then PROG_CYC cycles of prog_o, whether or not any write has happened.
- R5: If pwr_ok_i is low during the erase or program phase of a software save, the strobe drops after that clock edge. busy_o then stays high for exactly one more cycle.
- R6: A fall of pwr_ok_i while idle, with the dirty flag set, starts an automatic save. It has GRACE_CYC cycles with busy_o high, bus_block_o low and no strobe, then ERASE_CYC cycles of erase_o and PROG_CYC cycles of prog_o. Low supply does not abort it.
- R7: A write reported on wr_done_i while idle sets the dirty flag. A completed save or restore clears it. A fall of supply sense with the flag clear starts nothing.
- R8: busy_o rises in the cycle a transfer is accepted and falls one cycle after its last phase. bus_block_o equals busy_o except during the grace window. At most one strobe is high at a time, and only while busy_o is high.
- R9: Save or restore pulses that arrive while busy are ignored. A software save pulse while supply is low is ignored.
- R10: A software restore pulse while supply is low, or a supply rise while busy, is held. It produces exactly one restore of power-up length as soon as the controller is idle with supply high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_ok_i | input | 1 | Synchronised supply-sense flag, high when supply is good |
| sw_save_i | input | 1 | Software save request pulse |
| sw_restore_i | input | 1 | Software restore request pulse |
| wr_done_i | input | 1 | Pulse when a working-array write completes |
| busy_o | output | 1 | Transfer accepted or in progress |
| bus_block_o | output | 1 | Block external reads and writes |
| clr_o | output | 1 | Working-array clear phase |
| copy_o | output | 1 | Shadow-to-working copy phase |
| erase_o | output | 1 | Shadow erase phase |
| prog_o | output | 1 | Shadow program phase |

## Verification
The two functions that can land in one cycle are the automatic restore on a supply rise and a software save request. The bench raises pwr_ok_i and pulses sw_save_i on the same clock. It then expects an exact power-up restore trace followed by idle, with no erase or program afterwards. A supply rise is also forced in the middle of an automatic save's program phase. The bench then checks that the save finishes untouched and that the held restore begins on the very next idle cycle.

// File: rtl/nv_xfer_pkg.sv
package nv_xfer_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GRACE,
    ST_ERASE,
    ST_PROG,
    ST_CLEAR,
    ST_COPY,
    ST_DONE
  } nv_state_e;

  typedef enum logic [1:0] {
    K_AUTO_SAVE,
    K_SW_SAVE,
    K_PU_RST,
    K_SW_RST
  } nv_kind_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/nv_supply_edge.sv
module nv_supply_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_ok_i,
  output logic rise_o,
  output logic fall_o
);

  logic pwr_q;

  // reset value 0: supply already good at reset release counts as a rise
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pwr_q <= 1'b0;
    else         pwr_q <= pwr_ok_i;
  end

  assign rise_o = pwr_ok_i & ~pwr_q;
  assign fall_o = ~pwr_ok_i & pwr_q;

endmodule

// File: rtl/nv_phase_timer.sv
module nv_phase_timer #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] len_i,
  output logic          last_o
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= len_i - CW'(1);
    else if (cnt_q != '0)   cnt_q <= cnt_q - CW'(1);
  end

  assign last_o = (cnt_q == '0);

  AST_LEN_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> (len_i != '0)); // R8

endmodule

// File: rtl/nv_flag_track.sv
module nv_flag_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_dirty_i,
  input  logic clr_dirty_i,
  input  logic set_pend_i,
  input  logic clr_pend_i,
  output logic dirty_o,
  output logic pend_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dirty_o <= 1'b0;
      pend_o  <= 1'b0;
    end else begin
      if (clr_dirty_i)      dirty_o <= 1'b0;
      else if (set_dirty_i) dirty_o <= 1'b1;
      if (set_pend_i)       pend_o  <= 1'b1;
      else if (clr_pend_i)  pend_o  <= 1'b0;
    end
  end

  AST_DIRTY_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_dirty_i |=> !dirty_o); // R7
  AST_PEND_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_o && !clr_pend_i) |=> pend_o); // R10

endmodule

// File: rtl/nv_xfer_ctrl.sv
module nv_xfer_ctrl
  import nv_xfer_pkg::*;
#(
  parameter int GRACE_CYC  = 125,
  parameter int ERASE_CYC  = 600000,
  parameter int PROG_CYC   = 650000,
  parameter int CLR_CYC    = 64,
  parameter int SW_RST_CYC = 2500,
  parameter int PU_RST_CYC = 81250
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_ok_i,
  input  logic sw_save_i,
  input  logic sw_restore_i,
  input  logic wr_done_i,
  output logic busy_o,
  output logic bus_block_o,
  output logic clr_o,
  output logic copy_o,
  output logic erase_o,
  output logic prog_o
);

  localparam int MaxLen = max2(max2(max2(GRACE_CYC, ERASE_CYC), max2(PROG_CYC, CLR_CYC)),
                               max2(SW_RST_CYC, PU_RST_CYC));
  localparam int CW = $clog2(MaxLen + 1);

  nv_state_e     st_q, st_d;
  nv_kind_e      kind_q, kind_d;
  logic          accept, abort, aborted_q;
  logic          rise, fall, dirty, pend;
  logic          tmr_last, tmr_load;
  logic [CW-1:0] tmr_len;

  nv_supply_edge u_edge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pwr_ok_i (pwr_ok_i),
    .rise_o   (rise),
    .fall_o   (fall)
  );

  always_comb begin
    st_d   = st_q;
    kind_d = kind_q;
    accept = 1'b0;
    abort  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (fall && dirty) begin
          st_d = ST_GRACE;  kind_d = K_AUTO_SAVE; accept = 1'b1;
        end else if (pwr_ok_i && (rise || pend)) begin
          st_d = ST_CLEAR;  kind_d = K_PU_RST;    accept = 1'b1;
        end else if (pwr_ok_i && sw_save_i) begin
          st_d = ST_ERASE;  kind_d = K_SW_SAVE;   accept = 1'b1;
        end else if (pwr_ok_i && sw_restore_i) begin
          st_d = ST_CLEAR;  kind_d = K_SW_RST;    accept = 1'b1;
        end
      end
      ST_GRACE: if (tmr_last) st_d = ST_ERASE;
      ST_ERASE, ST_PROG: begin
        if (kind_q == K_SW_SAVE && !pwr_ok_i) begin
          st_d  = ST_DONE;
          abort = 1'b1;
        end else if (tmr_last) begin
          st_d = (st_q == ST_ERASE) ? ST_PROG : ST_DONE;
        end
      end
      ST_CLEAR: if (tmr_last) st_d = ST_COPY;
      ST_COPY:  if (tmr_last) st_d = ST_DONE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    case (st_d)
      ST_GRACE: tmr_len = CW'(GRACE_CYC);
      ST_ERASE: tmr_len = CW'(ERASE_CYC);
      ST_PROG:  tmr_len = CW'(PROG_CYC);
      ST_CLEAR: tmr_len = CW'(CLR_CYC);
      ST_COPY:  tmr_len = (kind_d == K_PU_RST) ? CW'(PU_RST_CYC) : CW'(SW_RST_CYC);
      default:  tmr_len = CW'(1);
    endcase
  end

  assign tmr_load = (st_d != st_q);

  nv_phase_timer #(.CW(CW)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .len_i  (tmr_len),
    .last_o (tmr_last)
  );

  nv_flag_track u_flags (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .set_dirty_i (wr_done_i && st_q == ST_IDLE),
    .clr_dirty_i (st_q == ST_DONE && !aborted_q),
    .set_pend_i  ((sw_restore_i && st_q == ST_IDLE && !pwr_ok_i) ||
                  (rise && st_q != ST_IDLE)),
    .clr_pend_i  (accept && kind_d == K_PU_RST),
    .dirty_o     (dirty),
    .pend_o      (pend)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      kind_q    <= K_AUTO_SAVE;
      aborted_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      kind_q <= kind_d;
      if (abort)                aborted_q <= 1'b1;
      else if (st_q == ST_DONE) aborted_q <= 1'b0;
    end
  end

  assign busy_o      = (st_q != ST_IDLE) || accept;
  assign bus_block_o = (st_q != ST_IDLE && st_q != ST_GRACE) || (accept && st_d != ST_GRACE);
  assign clr_o       = (st_q == ST_CLEAR);
  assign copy_o      = (st_q == ST_COPY);
  assign erase_o     = (st_q == ST_ERASE);
  assign prog_o      = (st_q == ST_PROG);

  AST_STROBE_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({clr_o, copy_o, erase_o, prog_o})); // R8
  AST_STROBE_IN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_o || copy_o || erase_o || prog_o) |-> (busy_o && bus_block_o)); // R8
  AST_PROG_AFTER_ERASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(prog_o) |-> $past(erase_o)); // R4
  AST_COPY_AFTER_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(copy_o) |-> $past(clr_o)); // R2
  AST_SW_SAVE_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((erase_o || prog_o) && kind_q == K_SW_SAVE && !pwr_ok_i) |=> (!erase_o && !prog_o && busy_o)); // R5
  AST_RESTORE_RUNS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (copy_o && !tmr_last) |=> copy_o); // R3
  AST_AUTO_SAVE_RUNS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (erase_o && kind_q == K_AUTO_SAVE && !tmr_last) |=> erase_o); // R6

endmodule

// File: tb/nv_xfer_ctrl_bench.sv
module nv_xfer_ctrl_bench;

  localparam int G  = 3;
  localparam int E  = 5;
  localparam int P  = 6;
  localparam int C  = 2;
  localparam int SR = 4;
  localparam int PU = 7;

  localparam int PH_IDLE  = 0;
  localparam int PH_ACCB  = 1;
  localparam int PH_ACCG  = 2;
  localparam int PH_GRACE = 3;
  localparam int PH_CLR   = 4;
  localparam int PH_COPY  = 5;
  localparam int PH_ERASE = 6;
  localparam int PH_PROG  = 7;
  localparam int PH_DONE  = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic pwr_ok = 1'b0, sw_save = 1'b0, sw_restore = 1'b0, wr_done = 1'b0;
  logic busy, bus_block, clr, copy, erase, prog;
  int checks = 0;
  int errors = 0;
  bit dirty_m = 1'b0;

  always #4 clk = ~clk;

  nv_xfer_ctrl #(
    .GRACE_CYC(G), .ERASE_CYC(E), .PROG_CYC(P),
    .CLR_CYC(C), .SW_RST_CYC(SR), .PU_RST_CYC(PU)
  ) u_nv_xfer_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .pwr_ok_i(pwr_ok),
    .sw_save_i(sw_save), .sw_restore_i(sw_restore), .wr_done_i(wr_done),
    .busy_o(busy), .bus_block_o(bus_block), .clr_o(clr), .copy_o(copy),
    .erase_o(erase), .prog_o(prog)
  );

  // expected {busy, bus_block, clr, copy, erase, prog}
  function automatic logic [5:0] pvec(input int ph);
    case (ph)
      PH_ACCB:  return 6'b110000;
      PH_ACCG:  return 6'b100000;
      PH_GRACE: return 6'b100000;
      PH_CLR:   return 6'b111000;
      PH_COPY:  return 6'b110100;
      PH_ERASE: return 6'b110010;
      PH_PROG:  return 6'b110001;
      PH_DONE:  return 6'b110000;
      default:  return 6'b000000;
    endcase
  endfunction

  task automatic cyc();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input logic [5:0] exp);
    logic [5:0] act;
    #1;
    act = {busy, bus_block, clr, copy, erase, prog};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_idle(input string req, input int n);
    for (int i = 0; i < n; i++) begin
      chk(req, pvec(PH_IDLE));
      cyc();
    end
  endtask

  // chg_k: 0 none, 1 drive pwr_ok to chg_v, 2 pulse sw_save
  task automatic expect_xfer(input string req, input int acc,
                             input int p0, input int l0, input int p1, input int l1,
                             input int p2, input int l2,
                             input int chg_k, input int chg_idx, input logic chg_v);
    int ph [3];
    int ln [3];
    int idx;
    ph[0] = p0; ph[1] = p1; ph[2] = p2;
    ln[0] = l0; ln[1] = l1; ln[2] = l2;
    chk(req, pvec(acc));
    cyc();
    sw_save = 1'b0; sw_restore = 1'b0; wr_done = 1'b0;
    idx = 1;
    for (int j = 0; j < 3; j++) begin
      for (int k = 0; k < ln[j]; k++) begin
        if (idx == chg_idx) begin
          if (chg_k == 1) pwr_ok = chg_v;
          else if (chg_k == 2) sw_save = 1'b1;
        end else if (chg_k == 2) begin
          sw_save = 1'b0;
        end
        chk(req, pvec(ph[j]));
        cyc();
        idx++;
      end
    end
    sw_save = 1'b0;
    chk(req, pvec(PH_DONE));
    cyc();
  endtask

  task automatic write_pulse(input string req);
    wr_done = 1'b1;
    check_idle(req, 1);
    wr_done = 1'b0;
    dirty_m = 1'b1;
  endtask

  task automatic pu_restore(input string req);
    pwr_ok = 1'b1;
    expect_xfer(req, PH_ACCB, PH_CLR, C, PH_COPY, PU, PH_IDLE, 0, 0, 0, 1'b0);
    dirty_m = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd1717));
    repeat (3) @(posedge clk);
    #2;
    rst_ni = 1'b1;
    check_idle("R1", 3);

    // supply rise and software save in the same cycle: restore wins
    pwr_ok = 1'b1;
    sw_save = 1'b1;
    expect_xfer("R2", PH_ACCB, PH_CLR, C, PH_COPY, PU, PH_IDLE, 0, 0, 0, 1'b0);
    check_idle("R2", 3);

    // fall without a write: nothing
    pwr_ok = 1'b0;
    check_idle("R7", 4);
    pu_restore("R2");
    check_idle("R2", 2);

    // write then fall: automatic save with grace
    write_pulse("R7");
    pwr_ok = 1'b0;
    expect_xfer("R6", PH_ACCG, PH_GRACE, G, PH_ERASE, E, PH_PROG, P, 0, 0, 1'b0);
    dirty_m = 1'b0;
    sw_save = 1'b1;
    check_idle("R9", 1);
    sw_save = 1'b0;
    check_idle("R9", 2);
    sw_restore = 1'b1;
    check_idle("R10", 1);
    sw_restore = 1'b0;
    check_idle("R10", 3);
    pu_restore("R10");
    check_idle("R10", 4);

    // software save clears dirty
    write_pulse("R7");
    sw_save = 1'b1;
    expect_xfer("R4", PH_ACCB, PH_ERASE, E, PH_PROG, P, PH_IDLE, 0, 0, 0, 1'b0);
    dirty_m = 1'b0;
    pwr_ok = 1'b0;
    check_idle("R7", 4);
    pu_restore("R2");
    check_idle("R2", 1);

    // software save with nothing written still runs
    sw_save = 1'b1;
    expect_xfer("R4", PH_ACCB, PH_ERASE, E, PH_PROG, P, PH_IDLE, 0, 0, 0, 1'b0);
    check_idle("R4", 2);

    // software restore survives a supply fall
    write_pulse("R7");
    sw_restore = 1'b1;
    expect_xfer("R3", PH_ACCB, PH_CLR, C, PH_COPY, SR, PH_IDLE, 0, 1, C + 2, 1'b0);
    dirty_m = 1'b0;
    check_idle("R3", 4);
    pu_restore("R3");
    check_idle("R3", 1);

    // save request while busy is ignored
    sw_restore = 1'b1;
    expect_xfer("R9", PH_ACCB, PH_CLR, C, PH_COPY, SR, PH_IDLE, 0, 2, 3, 1'b0);
    check_idle("R9", 4);

    // software save aborted by supply drop
    write_pulse("R7");
    sw_save = 1'b1;
    expect_xfer("R5", PH_ACCB, PH_ERASE, 2, PH_IDLE, 0, PH_IDLE, 0, 1, 2, 1'b0);
    check_idle("R5", 3);
    pu_restore("R5");
    check_idle("R5", 1);

    // supply rise during automatic save: restore right after
    write_pulse("R7");
    pwr_ok = 1'b0;
    expect_xfer("R6", PH_ACCG, PH_GRACE, G, PH_ERASE, E, PH_PROG, P, 1, G + E + 2, 1'b1);
    expect_xfer("R10", PH_ACCB, PH_CLR, C, PH_COPY, PU, PH_IDLE, 0, 0, 0, 1'b0);
    dirty_m = 1'b0;
    check_idle("R10", 3);

    // random mix
    for (int it = 0; it < 24; it++) begin
      int act;
      if ($urandom % 2 == 1) write_pulse("R7");
      check_idle("R8", $urandom % 3);
      act = $urandom % 3;
      if (act == 0) begin
        pwr_ok = 1'b0;
        if (dirty_m)
          expect_xfer("R6", PH_ACCG, PH_GRACE, G, PH_ERASE, E, PH_PROG, P, 0, 0, 1'b0);
        else
          check_idle("R7", 3);
        pu_restore("R2");
      end else if (act == 1) begin
        sw_save = 1'b1;
        expect_xfer("R4", PH_ACCB, PH_ERASE, E, PH_PROG, P, PH_IDLE, 0, 0, 0, 1'b0);
      end else begin
        sw_restore = 1'b1;
        expect_xfer("R3", PH_ACCB, PH_CLR, C, PH_COPY, SR, PH_IDLE, 0, 0, 0, 1'b0);
      end
      dirty_m = 1'b0;
      check_idle("R8", 1);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R8 watchdog: got running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule